// File: doc/BRIEF.md
# Masked Configuration Register Space

This block holds the 256-byte configuration space of a device. Every stored byte has a write mask byte next to it. A write lands on a byte only through that byte's mask. Bits that are masked off keep their old value, so read-only fields need no decode by address range. The mask table gets its reset layout from the header structure. When software-visible address regions are registered, the mask table is reloaded for each of those 32-bit base address registers, using the size and type of the region.

Writes of one, two or four bytes may start at any byte offset. They are applied little-endian and are cut off at the top of the space. If a write changes any base address byte, or changes the I/O or memory enable bits of the command byte, the block raises a one-cycle remap pulse. A downstream address decoder can use this pulse to rebuild its windows. The byte that holds the secondary bus number is driven out continuously. Reads return a 32-bit little-endian window one cycle after the address is presented.

Top module: `masked_cfg_space`

## Requirements
- R1: After reset every byte reads as zero, and remap_o and sec_bus_o are zero.
- R2: At reset, bytes 0x40 to 0xFF and the bytes at 0x0C and 0x3C are fully writable. Every other header byte (0x00 to 0x3F) ignores writes, except the bits listed in R3, until a registration changes its mask.
- R3: At reset, only bits 2:0 of the command byte at offset 0x04 are writable.
- R4: Each written byte becomes (old AND NOT mask) OR (data AND mask).
- R5: For a write of length 1, 2 or 4 at address A, data bits [8i+7:8i] go to byte A+i. No byte above 0xFF is touched, and there is no wraparound. A write with any other length has no effect.
- R6: Registration with index n from 0 to 5 targets the 32-bit register at 0x10+4n, and index 6 targets 0x30. It writes the type bits, zero-extended, into that register and sets the register's mask to NOT(2^k - 1), where k is the log2 size. For index 6, mask bit 0 is also set. Index 7 has no effect. When a registration and a write arrive in the same cycle, the registration is applied and the write is dropped.
- R7: A single-byte write into a base address register is accepted and stored through that byte's mask.
- R8: remap_o is high for exactly the cycle after a write that changes any byte in 0x10 to 0x27, or bit 0 or bit 1 of byte 0x04.
- R9: remap_o stays low after a write that changes none of the bits named in R8. This covers rewriting the same value, writing bit 2 of the command byte, and writing to the region at 0x30.
- R10: A registration never raises remap_o.
- R11: sec_bus_o always equals the stored byte at offset 0x19.
- R12: rd_data_o, in the cycle after rd_addr_i is presented, holds bytes rd_addr_i+0 to rd_addr_i+3 little-endian, with any byte past 0xFF read as zero. It shows the contents from before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write strobe |
| wr_addr_i | input | 8 | Byte offset of the first written byte |
| wr_len_i | input | LEN_W (3) | Write length in bytes: 1, 2 or 4 |
| wr_data_i | input | DATA_W (32) | Write data, lowest byte goes to wr_addr_i |
| reg_valid_i | input | 1 | Region registration strobe |
| reg_idx_i | input | 3 | Region index: 0 to 5 base address, 6 expansion ROM |
| reg_log2_i | input | LOG2_W (5) | log2 of the region size |
| reg_type_i | input | TYPE_W (4) | Type bits stored in the low bits of the register |
| rd_addr_i | input | 8 | Byte offset of the read window |
| rd_data_o | output | DATA_W (32) | Read window, registered |
| remap_o | output | 1 | One-cycle pulse when the address decode state changes |
| sec_bus_o | output | 8 | Stored secondary bus number byte |

## Verification
The assertions assume that reg_valid_i and wr_valid_i are held for one cycle per operation. They also assume that a cycle with a registration carries no write the bench expects to take effect. The stimulus drives each strobe for exactly one clock and collides the two strobes only in the scenario that checks priority. The property that ties remap_o to an earlier write also assumes inputs are stable around the edge. The bench meets this by changing every input on the falling clock edge.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned CFG_BYTES = 1 << ADDR_W;
  localparam int unsigned HDR_BYTES = 64;
  localparam int unsigned BAR_SLOTS = 6;
  localparam int unsigned IDX_W     = 3;

  localparam logic [7:0] CMD_OFS    = 8'h04;
  localparam logic [7:0] CLS_OFS    = 8'h0C;
  localparam logic [7:0] BAR_OFS    = 8'h10;
  localparam logic [7:0] SECBUS_OFS = 8'h19;
  localparam logic [7:0] ROM_OFS    = 8'h30;
  localparam logic [7:0] IRQLN_OFS  = 8'h3C;

  localparam logic [7:0] CMD_WMASK  = 8'h07;  // io, mem, master
  localparam logic [7:0] CMD_WATCH  = 8'h03;  // io, mem
  localparam logic [IDX_W-1:0] ROM_IDX = IDX_W'(BAR_SLOTS);

  function automatic logic [7:0] reset_wmask(int unsigned a);
    if (a >= HDR_BYTES) return 8'hFF;
    if (a == int'(CLS_OFS) || a == int'(IRQLN_OFS)) return 8'hFF;
    if (a == int'(CMD_OFS)) return CMD_WMASK;
    return 8'h00;
  endfunction

  // bits whose change must trigger a decode rebuild
  function automatic logic [7:0] watch_mask(int unsigned a);
    if (a >= int'(BAR_OFS) && a < int'(BAR_OFS) + 4 * BAR_SLOTS) return 8'hFF;
    if (a == int'(CMD_OFS)) return CMD_WATCH;
    return 8'h00;
  endfunction
endpackage

// File: rtl/cfg_wr_lanes.sv
module cfg_wr_lanes
  import cfg_space_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 3
) (
  input  logic                         go_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [LEN_W-1:0]             len_i,
  input  logic [DATA_W-1:0]            data_i,
  output logic [CFG_BYTES-1:0]         we_o,
  output logic [CFG_BYTES-1:0][7:0]    byte_o
);
  localparam int unsigned LANES = DATA_W / 8;
  localparam int unsigned SEL_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic len_ok;
  assign len_ok = (len_i != '0) && ((len_i & (len_i - LEN_W'(1))) == '0)
                  && (int'(len_i) <= int'(LANES));

  for (genvar a = 0; a < CFG_BYTES; a++) begin : g_lane
    localparam logic [ADDR_W:0] POS = (ADDR_W+1)'(a);
    logic [ADDR_W:0] ofs;
    assign ofs       = POS - {1'b0, addr_i};
    assign we_o[a]   = go_i && len_ok && !ofs[ADDR_W] && (ofs < (ADDR_W+1)'(len_i));
    assign byte_o[a] = data_i[{ofs[SEL_W-1:0], 3'b000} +: 8];
  end
endmodule

// File: rtl/cfg_reg_decode.sv
module cfg_reg_decode
  import cfg_space_pkg::*;
#(
  parameter int unsigned TYPE_W = 4,
  parameter int unsigned LOG2_W = 5
) (
  input  logic              go_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [LOG2_W-1:0] log2_i,
  input  logic [TYPE_W-1:0] type_i,
  output logic              hit_o,
  output logic [ADDR_W-3:0] row_o,
  output logic [31:0]       word_o,
  output logic [31:0]       mask_o
);
  logic        is_rom;
  logic [31:0] span;
  logic [7:0]  base;

  assign is_rom = (idx_i == ROM_IDX);
  assign hit_o  = go_i && (int'(idx_i) <= int'(BAR_SLOTS));
  assign base   = is_rom ? ROM_OFS : BAR_OFS + {3'b000, idx_i, 2'b00};
  assign row_o  = base[ADDR_W-1:2];
  assign span   = (32'd1 << log2_i) - 32'd1;
  assign word_o = {{(32-TYPE_W){1'b0}}, type_i};
  assign mask_o = ~span | {31'd0, is_rom};  // rom enable stays writable
endmodule

// File: rtl/cfg_byte_cell.sv
module cfg_byte_cell #(
  parameter logic [7:0] RST_MASK = 8'h00,
  parameter logic [7:0] WATCH    = 8'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_byte_i,
  input  logic       rg_en_i,
  input  logic [7:0] rg_byte_i,
  input  logic [7:0] rg_mask_i,
  output logic [7:0] q_o,
  output logic       chg_o
);
  logic [7:0] mask_q;
  logic [7:0] merged;

  assign merged = (q_o & ~mask_q) | (wr_byte_i & mask_q);
  assign chg_o  = wr_en_i && |((merged ^ q_o) & WATCH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o    <= 8'h00;
      mask_q <= RST_MASK;
    end else if (rg_en_i) begin
      q_o    <= rg_byte_i;
      mask_q <= rg_mask_i;
    end else if (wr_en_i) begin
      q_o    <= merged;
    end
  end
endmodule

// File: rtl/cfg_remap_detect.sv
module cfg_remap_detect
  import cfg_space_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CFG_BYTES-1:0] chg_i,
  output logic                 pulse_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_o <= 1'b0;
    else         pulse_o <= |chg_i;
  end
endmodule

// File: rtl/masked_cfg_space.sv
module masked_cfg_space
  import cfg_space_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = $clog2(DATA_W / 8 + 1),
  parameter int unsigned TYPE_W = 4,
  parameter int unsigned LOG2_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [7:0]        wr_addr_i,
  input  logic [LEN_W-1:0]  wr_len_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              reg_valid_i,
  input  logic [2:0]        reg_idx_i,
  input  logic [LOG2_W-1:0] reg_log2_i,
  input  logic [TYPE_W-1:0] reg_type_i,
  input  logic [7:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              remap_o,
  output logic [7:0]        sec_bus_o
);
  localparam int unsigned LANES = DATA_W / 8;

  logic [CFG_BYTES-1:0]      lane_we;
  logic [CFG_BYTES-1:0][7:0] lane_byte;
  logic [CFG_BYTES-1:0][7:0] cfg_q;
  logic [CFG_BYTES-1:0]      chg;
  logic                      rg_hit;
  logic [ADDR_W-3:0]         rg_row;
  logic [31:0]               rg_word;
  logic [31:0]               rg_mask;
  logic [DATA_W-1:0]         rd_next;
  logic [ADDR_W:0]           rd_pos;

  // registration wins over a same-cycle write
  cfg_wr_lanes #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_lanes (
    .go_i   (wr_valid_i && !reg_valid_i),
    .addr_i (wr_addr_i),
    .len_i  (wr_len_i),
    .data_i (wr_data_i),
    .we_o   (lane_we),
    .byte_o (lane_byte)
  );

  cfg_reg_decode #(.TYPE_W(TYPE_W), .LOG2_W(LOG2_W)) u_regdec (
    .go_i   (reg_valid_i),
    .idx_i  (reg_idx_i),
    .log2_i (reg_log2_i),
    .type_i (reg_type_i),
    .hit_o  (rg_hit),
    .row_o  (rg_row),
    .word_o (rg_word),
    .mask_o (rg_mask)
  );

  for (genvar a = 0; a < CFG_BYTES; a++) begin : g_cell
    localparam logic [ADDR_W-3:0] ROW = (ADDR_W-2)'(a >> 2);
    localparam int unsigned       SEL = a % 4;
    cfg_byte_cell #(
      .RST_MASK (reset_wmask(a)),
      .WATCH    (watch_mask(a))
    ) u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (lane_we[a]),
      .wr_byte_i (lane_byte[a]),
      .rg_en_i   (rg_hit && (rg_row == ROW)),
      .rg_byte_i (rg_word[8*SEL +: 8]),
      .rg_mask_i (rg_mask[8*SEL +: 8]),
      .q_o       (cfg_q[a]),
      .chg_o     (chg[a])
    );
  end

  cfg_remap_detect u_remap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .chg_i   (chg),
    .pulse_o (remap_o)
  );

  always_comb begin
    rd_next = '0;
    rd_pos  = '0;
    for (int l = 0; l < LANES; l++) begin
      rd_pos = {1'b0, rd_addr_i} + (ADDR_W+1)'(l);
      rd_next[8*l +: 8] = rd_pos[ADDR_W] ? 8'h00 : cfg_q[rd_pos[ADDR_W-1:0]];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else         rd_data_o <= rd_next;
  end

  assign sec_bus_o = cfg_q[SECBUS_OFS];
endmodule

// File: rtl/masked_cfg_space_chk.sv
module masked_cfg_space_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_i,
  input logic [LEN_W-1:0]  wr_len_i,
  input logic              reg_valid_i,
  input logic [7:0]        rd_addr_i,
  input logic [DATA_W-1:8] rd_hi_i,
  input logic              remap_o,
  input logic [7:0]        sec_bus_o
);
  logic len_bad;
  assign len_bad = (wr_len_i == '0) || ((wr_len_i & (wr_len_i - LEN_W'(1))) != '0)
                   || (int'(wr_len_i) > int'(DATA_W / 8));

  AST_REMAP_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni) remap_o |-> $past(wr_valid_i && !reg_valid_i)); // R8
  AST_REG_NO_REMAP: assert property (@(posedge clk_i) disable iff (!rst_ni) reg_valid_i |=> !remap_o); // R10
  AST_BAD_LEN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni) (wr_valid_i && len_bad) |=> !remap_o); // R5
  AST_SECBUS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni) (!wr_valid_i && !reg_valid_i) |=> $stable(sec_bus_o)); // R11
  AST_RD_TOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni) (rd_addr_i == 8'hFF) |=> (rd_hi_i == '0)); // R12
  AST_RD_TOP3_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni) (rd_addr_i >= 8'hFD) |=> (rd_hi_i[DATA_W-1:24] == '0)); // R12
endmodule

bind masked_cfg_space masked_cfg_space_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_valid_i  (wr_valid_i),
  .wr_len_i    (wr_len_i),
  .reg_valid_i (reg_valid_i),
  .rd_addr_i   (rd_addr_i),
  .rd_hi_i     (rd_data_o[DATA_W-1:8]),
  .remap_o     (remap_o),
  .sec_bus_o   (sec_bus_o)
);

// File: tb/masked_cfg_space_test.sv
module masked_cfg_space_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [2:0]  wr_len = '0;
  logic [31:0] wr_data = '0;
  logic        reg_valid = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic [4:0]  reg_log2 = '0;
  logic [3:0]  reg_type = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        remap;
  logic [7:0]  sec_bus;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic last_remap;

  always #4 clk = ~clk;  // 125 MHz

  masked_cfg_space uut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_addr_i(wr_addr), .wr_len_i(wr_len), .wr_data_i(wr_data),
    .reg_valid_i(reg_valid), .reg_idx_i(reg_idx), .reg_log2_i(reg_log2), .reg_type_i(reg_type),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .remap_o(remap), .sec_bus_o(sec_bus)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [2:0] l);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_len = l;
    @(negedge clk);
    wr_valid = 1'b0;
    last_remap = remap;
  endtask

  task automatic rgn(logic [2:0] i, logic [4:0] k, logic [3:0] t);
    @(negedge clk);
    reg_valid = 1'b1; reg_idx = i; reg_log2 = k; reg_type = t;
    @(negedge clk);
    reg_valid = 1'b0;
    last_remap = remap;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h00, d); chk("R1 byte 0x00", d, 32'h0);
    rd(8'h40, d); chk("R1 byte 0x40", d, 32'h0);
    chk("R1 remap", {31'd0, remap}, 32'd0);
    chk("R1 sec_bus", {24'd0, sec_bus}, 32'd0);
  endtask

  task automatic t_hdr_mask();
    logic [31:0] d;
    wr(8'h00, 32'hFFFF_FFFF, 3'd4);
    rd(8'h00, d); chk("R2 ident read-only", d, 32'h0);
    wr(8'h0C, 32'h0000_00A5, 3'd1);
    rd(8'h0C, d); chk("R2 cache line writable", d, 32'h0000_00A5);
    wr(8'h3C, 32'h1122_3344, 3'd4);
    rd(8'h3C, d); chk("R2 irq line only", d, 32'h0000_0044);
    wr(8'h40, 32'hDEAD_BEEF, 3'd4);
    rd(8'h40, d); chk("R4 tail writable", d, 32'hDEAD_BEEF);
  endtask

  task automatic t_cmd();
    logic [31:0] d;
    wr(8'h04, 32'h0000_FFFF, 3'd2);
    chk("R8 cmd enable remap", {31'd0, last_remap}, 32'd1);
    rd(8'h04, d); chk("R3 cmd mask", d, 32'h0000_0007);
    wr(8'h04, 32'h0000_0003, 3'd1);
    chk("R9 master bit no remap", {31'd0, last_remap}, 32'd0);
    rd(8'h04, d); chk("R4 cmd update", d, 32'h0000_0003);
    wr(8'h04, 32'h0000_0000, 3'd1);
    chk("R8 cmd clear remap", {31'd0, last_remap}, 32'd1);
  endtask

  task automatic t_lanes();
    logic [31:0] d;
    wr(8'hFE, 32'h1122_3344, 3'd4);
    chk("R9 tail no remap", {31'd0, last_remap}, 32'd0);
    rd(8'hFC, d); chk("R5 clip at top", d, 32'h3344_0000);
    rd(8'hFE, d); chk("R12 zero past top", d, 32'h0000_3344);
    wr(8'h50, 32'h00AA_BBCC, 3'd3);
    rd(8'h50, d); chk("R5 len3 ignored", d, 32'h0);
    wr(8'h60, 32'h1234_5678, 3'd2);
    rd(8'h60, d); chk("R5 len2 little-endian", d, 32'h0000_5678);
  endtask

  task automatic t_regions();
    logic [31:0] d;
    rgn(3'd0, 5'd4, 4'h0);
    chk("R10 reg no remap", {31'd0, last_remap}, 32'd0);
    wr(8'h10, 32'h0000_00FF, 3'd1);
    chk("R8 bar remap", {31'd0, last_remap}, 32'd1);
    rd(8'h10, d); chk("R7 byte write masked", d, 32'h0000_00F0);
    wr(8'h12, 32'h0000_00AB, 3'd1);
    rd(8'h10, d); chk("R7 upper byte write", d, 32'h00AB_00F0);
    wr(8'h12, 32'h0000_00AB, 3'd1);
    chk("R9 same value no remap", {31'd0, last_remap}, 32'd0);
    rgn(3'd1, 5'd8, 4'h1);
    rd(8'h14, d); chk("R6 type written", d, 32'h0000_0001);
    wr(8'h14, 32'hFFFF_FFFF, 3'd4);
    rd(8'h14, d); chk("R6 size mask", d, 32'hFFFF_FF01);
    rgn(3'd6, 5'd11, 4'h0);
    wr(8'h30, 32'hFFFF_FFFF, 3'd4);
    chk("R9 rom no remap", {31'd0, last_remap}, 32'd0);
    rd(8'h30, d); chk("R6 rom enable bit", d, 32'hFFFF_F801);
    rgn(3'd7, 5'd0, 4'hF);
    rd(8'h30, d); chk("R6 idx7 rom kept", d, 32'hFFFF_F801);
    rd(8'h10, d); chk("R6 idx7 bar0 kept", d, 32'h00AB_00F0);
  endtask

  task automatic t_bus();
    logic [31:0] d;
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 8'h44; wr_data = 32'h55; wr_len = 3'd1;
    reg_valid = 1'b1; reg_idx = 3'd2; reg_log2 = 5'd0; reg_type = 4'h5;
    @(negedge clk);
    wr_valid = 1'b0; reg_valid = 1'b0;
    chk("R10 collide no remap", {31'd0, remap}, 32'd0);
    rd(8'h44, d); chk("R6 write dropped", d, 32'h0);
    rd(8'h18, d); chk("R6 reg applied", d, 32'h0000_0005);
    wr(8'h18, 32'h0000_3412, 3'd2);
    chk("R11 sec bus word", {24'd0, sec_bus}, 32'h34);
    chk("R8 bus bytes remap", {31'd0, last_remap}, 32'd1);
    wr(8'h19, 32'h0000_007E, 3'd1);
    chk("R11 sec bus byte", {24'd0, sec_bus}, 32'h7E);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_hdr_mask();
    t_cmd();
    t_lanes();
    t_regions();
    t_bus();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule